// File: doc/BRIEF.md
# Two-Slot Packet Buffer Allocator

This block tracks who owns each of two packet buffers that a link controller and its client logic share. A client asks for a buffer with a one-cycle request strobe. The block answers with a one-cycle grant that carries the slot index, and it marks that slot busy. A client hands a buffer back by strobing a release with the slot index. The buffer storage and the packet contents sit outside this block. Only ownership is tracked here.

When both slots are taken, one request can wait. The next valid release then gives its slot straight to the waiter: the slot stays busy and the waiting record clears. A second waiting request is protocol misuse, and so is a release naming a slot that does not exist. Either one sets a sticky error flag. After that the block freezes: requests get no grant and releases change nothing. Only a synchronous reset clears the error.

All outputs are registered. A strobe sampled on one rising edge shows its effect on the outputs right after that edge.

Top module: `buf_pair_alloc`

## Requirements
- R1: While reset is high, at the next rising edge every busy flag clears, the waiting flag clears, the error flag clears and no grant is driven.
- R2: A request with a free slot grants the lowest-numbered free slot. Slot 0 wins over slot 1. The grant is a single-cycle pulse on `grantValid` with the index on `grantSlot`, and the granted slot's busy flag is set.
- R3: A request that finds both slots busy and nothing waiting produces no grant and sets `pendingReq`. The busy flags stay unchanged.
- R4: A request that arrives while a request is already waiting, with no valid release in the same cycle, sets the error flag.
- R5: A release whose index is 2 or more sets the error flag. Valid indices are 0 and 1.
- R6: A valid release while a request is waiting does three things: it grants the released index to the waiter on the next cycle, leaves that slot busy, and clears `pendingReq`.
- R7: A valid release with nothing waiting clears that slot's busy flag and produces no grant.
- R8: When a request and a release arrive in the same cycle, the release is applied first. The request then sees the busy and waiting state as the release left it.
- R9: Once the error flag is set, it stays set until reset. While it is set, there are no grants and the busy and waiting flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request a free buffer this cycle |
| relValid | input | 1 | Release a buffer this cycle |
| relSlot | input | REL_W | Index of the released buffer |
| grantValid | output | 1 | One-cycle grant pulse |
| grantSlot | output | 1 | Index of the granted buffer |
| busy | output | 2 | Per-slot ownership flags |
| pendingReq | output | 1 | A request is waiting for a release |
| errFlag | output | 1 | Sticky protocol-misuse flag |

## Verification
The bench goes after five corner cases, each with the fault it would expose:
- A release and a request in the same cycle while both slots are full. If the design handled the request first, it would record a waiter or raise a false error instead of handing the freed slot over.
- A release while a request waits. A design that cleared the busy flag here would leave a buffer looking free while the waiter owns it.
- A back-to-back second request while one waits. This checks that the error flag rises.
- An out-of-range release index. This also checks that the error flag rises.
- Traffic after the error flag is set. A design that leaked state changes or grants after the error would fail here.

Random strobes with mixed valid and invalid indices are compared each cycle against an independent model.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] setBusy;
    logic [NUM_SLOTS-1:0] clrBusy;
    logic                 setPend;
    logic                 clrPend;
    logic                 grant;
    logic [SLOT_W-1:0]    grantIdx;
    logic                 raiseErr;
  } allocStrobes_t;
endpackage

// File: rtl/slot_alloc_ctrl.sv
module slot_alloc_ctrl
  import slot_alloc_pkg::*;
#(
  parameter int REL_W = 2
) (
  input  logic                 reqValid,
  input  logic                 relValid,
  input  logic [REL_W-1:0]     relSlot,
  input  logic [NUM_SLOTS-1:0] busyNow,
  input  logic                 pendNow,
  input  logic                 errNow,
  output allocStrobes_t        strb
);
  localparam logic [31:0] SLOT_LIMIT = 32'(NUM_SLOTS);

  logic                 relInRange;
  logic                 relOk;
  logic                 relBad;
  logic                 handOff;
  logic [SLOT_W-1:0]    relIdx;
  logic [NUM_SLOTS-1:0] relHot;
  logic [NUM_SLOTS-1:0] busyAfter;
  logic                 pendAfter;
  logic                 freeFound;
  logic [SLOT_W-1:0]    freeIdx;
  logic [NUM_SLOTS-1:0] freeHot;

  assign relInRange = ({{(32-REL_W){1'b0}}, relSlot} < SLOT_LIMIT);
  assign relOk      = relValid && relInRange;
  assign relBad     = relValid && !relInRange;
  assign relIdx     = relSlot[SLOT_W-1:0];
  assign handOff    = relOk && pendNow;

  // one-hot decode of the released slot and the picked free slot
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_hot
      assign relHot[gi]    = relOk && (relIdx == SLOT_W'(gi));
      assign busyAfter[gi] = busyNow[gi] && !(relHot[gi] && !pendNow);
      assign freeHot[gi]   = freeFound && (freeIdx == SLOT_W'(gi));
    end
  endgenerate

  assign pendAfter = pendNow && !handOff;

  // lowest free index after the release has been applied
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!busyAfter[i]) begin
        freeFound = 1'b1;
        freeIdx   = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    strb = '0;
    if (!errNow) begin
      if (relBad) begin
        strb.raiseErr = 1'b1;
      end else begin
        if (handOff) begin
          strb.grant    = 1'b1;
          strb.grantIdx = relIdx;
          strb.clrPend  = 1'b1;
        end else begin
          strb.clrBusy = relHot;
        end
        if (reqValid) begin
          if (pendAfter) begin
            strb.raiseErr = 1'b1;
          end else if (freeFound) begin
            strb.grant    = 1'b1;
            strb.grantIdx = freeIdx;
            strb.setBusy  = freeHot;
          end else begin
            strb.setPend = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/slot_alloc_state.sv
module slot_alloc_state
  import slot_alloc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  allocStrobes_t        strb,
  output logic [NUM_SLOTS-1:0] busyQ,
  output logic                 pendQ,
  output logic                 errQ,
  output logic                 grantQ,
  output logic [SLOT_W-1:0]    grantIdxQ
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_busy
      always_ff @(posedge clk) begin
        if (rst) begin
          busyQ[gi] <= 1'b0;
        end else if (!strb.raiseErr) begin
          if (strb.setBusy[gi])      busyQ[gi] <= 1'b1;
          else if (strb.clrBusy[gi]) busyQ[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ     <= 1'b0;
      errQ      <= 1'b0;
      grantQ    <= 1'b0;
      grantIdxQ <= '0;
    end else begin
      errQ   <= errQ || strb.raiseErr;
      grantQ <= strb.grant && !strb.raiseErr;
      if (strb.grant && !strb.raiseErr) grantIdxQ <= strb.grantIdx;
      if (!strb.raiseErr) begin
        if (strb.setPend)      pendQ <= 1'b1;
        else if (strb.clrPend) pendQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/buf_pair_alloc.sv
module buf_pair_alloc
  import slot_alloc_pkg::*;
#(
  parameter int REL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 relValid,
  input  logic [REL_W-1:0]     relSlot,
  output logic                 grantValid,
  output logic [SLOT_W-1:0]    grantSlot,
  output logic [NUM_SLOTS-1:0] busy,
  output logic                 pendingReq,
  output logic                 errFlag
);
  allocStrobes_t strb;

  slot_alloc_ctrl #(.REL_W(REL_W)) u_ctrl (
    .reqValid (reqValid),
    .relValid (relValid),
    .relSlot  (relSlot),
    .busyNow  (busy),
    .pendNow  (pendingReq),
    .errNow   (errFlag),
    .strb     (strb)
  );

  slot_alloc_state u_state (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .busyQ     (busy),
    .pendQ     (pendingReq),
    .errQ      (errFlag),
    .grantQ    (grantValid),
    .grantIdxQ (grantSlot)
  );
endmodule

// File: rtl/buf_pair_alloc_chk.sv
module buf_pair_alloc_chk
  import slot_alloc_pkg::*;
#(
  parameter int REL_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reqValid,
  input logic                 relValid,
  input logic [REL_W-1:0]     relSlot,
  input logic                 grantValid,
  input logic [SLOT_W-1:0]    grantSlot,
  input logic [NUM_SLOTS-1:0] busy,
  input logic                 pendingReq,
  input logic                 errFlag
);
  logic relGood;
  assign relGood = relValid && (int'(relSlot) < NUM_SLOTS);

  // R2
  grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
    grantValid |-> busy[grantSlot]);

  // R3
  pend_full_chk: assert property (@(posedge clk) disable iff (rst)
    pendingReq |-> (&busy));

  // R4
  double_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!errFlag && pendingReq && reqValid && !relValid) |=> errFlag);

  // R5
  bad_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (relValid && !relGood) |=> errFlag);

  // R6
  hand_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!errFlag && relGood && pendingReq) |=>
      (grantValid && grantSlot == $past(relSlot[SLOT_W-1:0]) && busy[grantSlot]));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R9
  err_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> ($stable(busy) && $stable(pendingReq) && !grantValid));
endmodule

bind buf_pair_alloc buf_pair_alloc_chk #(.REL_W(REL_W)) u_chk (.*);

// File: tb/buf_pair_alloc_bench.sv
module buf_pair_alloc_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic       relValid = 1'b0;
  logic [1:0] relSlot = '0;
  logic       grantValid;
  logic [0:0] grantSlot;
  logic [1:0] busy;
  logic       pendingReq;
  logic       errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit [1:0] mBusy;
  bit       mPend;
  bit       mErr;
  bit       expGv;
  bit       expGs;

  always #5 clk = ~clk;

  buf_pair_alloc u_buf_pair_alloc (
    .clk(clk), .rst(rst), .reqValid(reqValid), .relValid(relValid),
    .relSlot(relSlot), .grantValid(grantValid), .grantSlot(grantSlot),
    .busy(busy), .pendingReq(pendingReq), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelApply(input bit rq, input bit rv, input int rs);
    bit [1:0] nb;
    bit       np;
    expGv = 0;
    expGs = 0;
    if (mErr) return;
    if (rv && rs >= 2) begin mErr = 1; return; end
    nb = mBusy;
    np = mPend;
    if (rv) begin
      if (np) begin expGv = 1; expGs = rs[0]; np = 0; end
      else nb[rs[0]] = 1'b0;
    end
    if (rq) begin
      if (np) begin mErr = 1; expGv = 0; return; end
      else if (!nb[0]) begin nb[0] = 1'b1; expGv = 1; expGs = 0; end
      else if (!nb[1]) begin nb[1] = 1'b1; expGv = 1; expGs = 1; end
      else np = 1;
    end
    mBusy = nb;
    mPend = np;
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "grantValid", int'(grantValid), int'(expGv));
    if (expGv) chk(tag, "grantSlot", int'(grantSlot), int'(expGs));
    chk(tag, "busy", int'(busy), int'(mBusy));
    chk(tag, "pendingReq", int'(pendingReq), int'(mPend));
    chk(tag, "errFlag", int'(errFlag), int'(mErr));
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input bit rq, input bit rv, input int rs, input string tag);
    reqValid = rq;
    relValid = rv;
    relSlot  = 2'(rs);
    modelApply(rq, rv, rs);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    relValid = 0;
    checkAll(tag);
  endtask

  task automatic doReset(input string tag);
    rst = 1;
    reqValid = 0;
    relValid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    mBusy = 0; mPend = 0; mErr = 0; expGv = 0; expGs = 0;
    checkAll(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    @(negedge clk);
    doReset("R1");
    step(1, 0, 0, "R2 slot0");
    step(0, 0, 0, "R2 pulse ends");
    step(1, 0, 0, "R2 slot1");
    step(1, 0, 0, "R3 pending");
    step(0, 1, 1, "R6 handoff");
    step(0, 1, 0, "R7 release");
    step(1, 0, 0, "R2 refill slot0");
    step(1, 1, 1, "R8 release then request");
    step(1, 0, 0, "R3 pending again");
    step(1, 0, 0, "R4 double request");
    step(1, 1, 0, "R9 frozen");
    step(0, 1, 1, "R9 frozen release");
    doReset("R1 after error");
    step(1, 0, 0, "R2 slot0");
    step(0, 1, 2, "R5 bad index");
    step(1, 0, 0, "R9 no grant");
    doReset("R1");
    step(0, 1, 3, "R5 bad index 3");
    doReset("R1");
    for (int n = 0; n < 400; n++) begin
      int r;
      int rs;
      r = $urandom_range(0, 99);
      rs = (r < 6) ? $urandom_range(2, 3) : $urandom_range(0, 1);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, rs, "R8 random");
      if (mErr && $urandom_range(0, 3) == 0) doReset("R1 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule